// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block sits in front of a scratchpad memory split into as many banks as there are lanes. Every lane can touch one bank in the same cycle. A group request carries an active bit, a byte address and write data for each lane, plus one read/write flag for the whole group. The block works out the bank each lane addresses. It then serves the group in one or more conflict-free passes and hands read data back to each lane. A pass is needed again only when distinct words of one bank are asked for.

Lanes that name the same word of a bank ride in the same pass. On a read the fetched word goes to all of them. On a write a single lane's value lands, and that lane is the lowest-numbered one. A mode input chooses whether a bank word is 4 or 8 bytes wide, and this changes the address-to-bank mapping. A ready/done handshake holds off the next group until the last pass has run. The number of passes spent on the last group is exported.

Top module: `scratch_bank_serializer`

## Requirements
- R1: With `wideBanks`=0 a lane's bank is address bits [6:2], and its bank word is address bits [11:2]. A group whose lanes name distinct banks completes in one pass. Lanes 0 and 16 reading byte addresses 0 and 128 conflict.
- R2: With `wideBanks`=1 a lane's bank is address bits [7:3], and its bank word is address bits [11:3]. Lanes reading the two 4-byte halves of one 8-byte word share a pass, and each lane still gets its own 4-byte half.
- R3: Lanes naming N distinct words of one bank take N passes. All 32 lanes in one bank at distinct words take 32 passes. Three lanes in one 8-byte bank at three 8-byte words take 3 passes.
- R4: Lanes reading the same word share one pass, and all of them receive that word.
- R5: When several lanes write the same 4-byte word in one group, only the value of the lowest-numbered such lane is stored.
- R6: In each pass every bank serves the word of its lowest-numbered pending lane. Every pending lane naming that word retires in the same pass, so lanes 0..3 on one bank at words A,B,B,A take 2 passes.
- R7: `reqReady` is 1 only when idle. A group is taken when `reqValid` and `reqReady` are both 1. `reqReady` drops the cycle after a take. `rspDone` is a one-cycle pulse raised together with the return of `reqReady`.
- R8: `rspDone` rises max(P,1) clock edges after the take edge, where P is the pass count of the group.
- R9: Inactive lanes neither write memory nor return data, and their `rspRdata` slice reads 0. A group with no active lane finishes after one edge with a pass count of 0.
- R10: At `rspDone` every active read lane holds its word in `rspRdata`, and write lanes read 0. These values are held until the next take.
- R11: After reset `reqReady`=1, `rspDone`=0 and `passCount`=0. `passCount` shows the passes of the last group and holds until the next take.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Group request present |
| reqReady | output | 1 | Block idle and able to take a group |
| reqActive | input | LANES | Per-lane active bits |
| reqAddr | input | LANES*ADDR_W | Per-lane byte address, lane i at bits [i*ADDR_W +: ADDR_W] |
| reqWrite | input | 1 | 1 = write group, 0 = read group |
| reqWdata | input | LANES*32 | Per-lane write data, lane i at bits [i*32 +: 32] |
| wideBanks | input | 1 | 0 = 4-byte bank words, 1 = 8-byte bank words |
| rspDone | output | 1 | One-cycle pulse when the group has finished |
| rspRdata | output | LANES*32 | Per-lane read data, lane i at bits [i*32 +: 32] |
| passCount | output | $clog2(LANES+1) | Passes used by the last group |

## Verification
A take lands on a rising edge. `reqReady` is low from that edge until `rspDone` appears, and `rspDone` follows exactly max(P,1) edges after the take. The bench drives and samples on falling edges. It counts rising edges from the take to the first falling edge that shows `rspDone`, and compares that count and `passCount` with the number of passes each scenario needs by construction. It checks read data and the held outputs only at or after that falling edge, and checks `rspDone` low again one edge later.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;   // latch a new group
    logic runPass;   // execute one conflict-free pass
  } ctrl_strobe_t;
endpackage

// File: rtl/sbs_datapath.sv
module sbs_datapath
  import sbs_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int ADDR_W = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrl_strobe_t            strb,
  input  logic [LANES-1:0]        reqActive,
  input  logic [LANES*ADDR_W-1:0] reqAddr,
  input  logic                    reqWrite,
  input  logic [LANES*32-1:0]     reqWdata,
  input  logic                    wideBanks,
  output logic                    anyPending,
  output logic                    lastPass,
  output logic [LANES*32-1:0]     rspRdata
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int DEPTH  = 1 << WORD_W;
  localparam int BANK_W = $clog2(LANES);

  logic [LANES-1:0]  pending;
  logic              writeQ;
  logic              wideQ;
  logic [WORD_W-1:0] wordQ [LANES];
  logic [31:0]       wdataQ [LANES];
  logic [31:0]       rdataQ [LANES];
  logic [31:0]       mem [DEPTH];

  logic [WORD_W-1:0] key [LANES];
  logic [BANK_W-1:0] bank [LANES];
  logic [LANES-1:0]  leader;
  logic [LANES-1:0]  served;

  logic unusedAddrBits;
  always_comb begin
    unusedAddrBits = 1'b0;
    for (int i = 0; i < LANES; i++)
      unusedAddrBits = unusedAddrBits ^ (^reqAddr[i*ADDR_W +: 2]);
  end

  // bank word key and bank per lane under the latched mode
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      key[i]  = wideQ ? (wordQ[i] >> 1) : wordQ[i];
      bank[i] = key[i][BANK_W-1:0];
    end
  end

  // leader: lowest pending lane of its bank; served: lane names the leader's word
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      leader[i] = pending[i];
      for (int j = 0; j < i; j++)
        if (pending[j] && bank[j] == bank[i]) leader[i] = 1'b0;
    end
    for (int i = 0; i < LANES; i++) begin
      served[i] = 1'b0;
      for (int j = 0; j <= i; j++)
        if (pending[i] && leader[j] && key[j] == key[i]) served[i] = 1'b1;
    end
  end

  assign anyPending = |pending;
  assign lastPass   = (pending & ~served) == '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
      writeQ  <= 1'b0;
      wideQ   <= 1'b0;
      for (int i = 0; i < LANES; i++) begin
        wordQ[i]  <= '0;
        wdataQ[i] <= '0;
        rdataQ[i] <= '0;
      end
    end else if (strb.capture) begin
      pending <= reqActive;
      writeQ  <= reqWrite;
      wideQ   <= wideBanks;
      for (int i = 0; i < LANES; i++) begin
        wordQ[i]  <= reqAddr[i*ADDR_W+2 +: WORD_W];
        wdataQ[i] <= reqWdata[i*32 +: 32];
        rdataQ[i] <= '0;
      end
    end else if (strb.runPass) begin
      pending <= pending & ~served;
      if (!writeQ)
        for (int i = 0; i < LANES; i++)
          if (served[i]) rdataQ[i] <= mem[wordQ[i]];
    end
  end

  // descending order: the lowest served lane's assignment is the last one
  always_ff @(posedge clk) begin
    if (strb.runPass && writeQ)
      for (int i = LANES-1; i >= 0; i--)
        if (served[i]) mem[wordQ[i]] <= wdataQ[i];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    assign rspRdata[g*32 +: 32] = rdataQ[g];
  end
endmodule

// File: rtl/sbs_control.sv
module sbs_control
  import sbs_pkg::*;
#(
  parameter int LANES = 32,
  localparam int CNT_W = $clog2(LANES+1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             anyPending,
  input  logic             lastPass,
  output ctrl_strobe_t     strb,
  output logic             reqReady,
  output logic             rspDone,
  output logic [CNT_W-1:0] passCount
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_t;
  state_t state;

  assign reqReady     = (state == ST_IDLE);
  assign strb.capture = reqReady && reqValid;
  assign strb.runPass = (state == ST_BUSY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rspDone   <= 1'b0;
      passCount <= '0;
    end else begin
      rspDone <= 1'b0;
      case (state)
        ST_IDLE: if (reqValid) begin
          state     <= ST_BUSY;
          passCount <= '0;
        end
        ST_BUSY: begin
          if (anyPending) passCount <= passCount + 1'b1;
          if (lastPass) begin
            state   <= ST_IDLE;
            rspDone <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scratch_bank_serializer.sv
module scratch_bank_serializer
  import sbs_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int ADDR_W = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  output logic                       reqReady,
  input  logic [LANES-1:0]           reqActive,
  input  logic [LANES*ADDR_W-1:0]    reqAddr,
  input  logic                       reqWrite,
  input  logic [LANES*32-1:0]        reqWdata,
  input  logic                       wideBanks,
  output logic                       rspDone,
  output logic [LANES*32-1:0]        rspRdata,
  output logic [$clog2(LANES+1)-1:0] passCount
);
  ctrl_strobe_t strb;
  logic anyPending;
  logic lastPass;

  sbs_control #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .anyPending(anyPending), .lastPass(lastPass), .strb(strb),
    .reqReady(reqReady), .rspDone(rspDone), .passCount(passCount)
  );

  sbs_datapath #(.LANES(LANES), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqActive(reqActive),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .wideBanks(wideBanks), .anyPending(anyPending), .lastPass(lastPass),
    .rspRdata(rspRdata)
  );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int LANES = 32
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       reqValid,
  input logic                       reqReady,
  input logic [LANES-1:0]           reqActive,
  input logic                       rspDone,
  input logic [$clog2(LANES+1)-1:0] passCount
);
  logic groupHadLane;
  always_ff @(posedge clk) begin
    if (!rstN) groupHadLane <= 1'b0;
    else if (reqValid && reqReady) groupHadLane <= |reqActive;
  end

  p_done_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> reqReady);
  p_busy_after_take_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> (passCount <= LANES));
  p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspDone && !groupHadLane) |-> (passCount == 0));
  p_lanes_need_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspDone && groupHadLane) |-> (passCount != 0));
  p_count_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !reqValid) |=> $stable(passCount));
endmodule

bind scratch_bank_serializer sbs_checker #(.LANES(LANES)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqActive(reqActive), .rspDone(rspDone), .passCount(passCount)
);

// File: tb/sim_scratch_bank_serializer.sv
module sim_scratch_bank_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 32;
  localparam int ADDR_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [LANES-1:0] reqActive = '0;
  logic [LANES*ADDR_W-1:0] reqAddr = '0;
  logic reqWrite = 1'b0;
  logic [LANES*32-1:0] reqWdata = '0;
  logic wideBanks = 1'b0;
  logic rspDone;
  logic [LANES*32-1:0] rspRdata;
  logic [5:0] passCount;

  int nChecks = 0;
  int nFails = 0;
  int tAddr [LANES];
  int tData [LANES];
  logic [LANES-1:0] tAct;

  always #(CLK_PERIOD/2) clk = ~clk;

  scratch_bank_serializer #(.LANES(LANES), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqActive(reqActive), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .wideBanks(wideBanks), .rspDone(rspDone),
    .rspRdata(rspRdata), .passCount(passCount)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int laneData(input int i);
    return int'(rspRdata[i*32 +: 32]);
  endfunction

  // issue one group and check handshake, timing and pass count
  task automatic runGroup(input logic wr, input logic wide, input int expPasses, input string tag);
    int edges = 0;
    @(negedge clk);
    check(reqReady == 1'b1, {tag, " R7 ready before take"}, int'(reqReady), 1);
    check(rspDone == 1'b0, {tag, " R7 done is a single pulse"}, int'(rspDone), 0);
    for (int i = 0; i < LANES; i++) begin
      reqAddr[i*ADDR_W +: ADDR_W] = tAddr[i][ADDR_W-1:0];
      reqWdata[i*32 +: 32] = tData[i];
    end
    reqActive = tAct;
    reqWrite = wr;
    wideBanks = wide;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, {tag, " R7 ready low after take"}, int'(reqReady), 0);
    forever begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (rspDone) break;
      if (reqReady) begin
        check(1'b0, {tag, " R7 ready while busy"}, 1, 0);
        break;
      end
    end
    check(reqReady == 1'b1, {tag, " R7 ready with done"}, int'(reqReady), 1);
    check(edges == ((expPasses > 1) ? expPasses : 1), {tag, " R8 done latency"}, edges,
          (expPasses > 1) ? expPasses : 1);
    check(int'(passCount) == expPasses, {tag, " pass count"}, int'(passCount), expPasses);
  endtask

  task automatic clearLanes();
    for (int i = 0; i < LANES; i++) begin
      tAddr[i] = 0;
      tData[i] = 0;
    end
    tAct = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(reqReady == 1'b1, "R11 reset ready", int'(reqReady), 1);
    check(rspDone == 1'b0, "R11 reset done", int'(rspDone), 0);
    check(passCount == 6'd0, "R11 reset count", int'(passCount), 0);
  endtask

  task automatic t_linear();
    clearLanes();
    tAct = '1;
    for (int i = 0; i < LANES; i++) begin
      tAddr[i] = 4*i;
      tData[i] = 100 + i;
    end
    runGroup(1'b1, 1'b0, 1, "R1 linear write");
    check(laneData(3) == 0, "R10 write lane reads 0", laneData(3), 0);
    runGroup(1'b0, 1'b0, 1, "R1 linear read");
    for (int i = 0; i < LANES; i++)
      check(laneData(i) == 100 + i, "R10 linear read data", laneData(i), 100 + i);
  endtask

  task automatic t_modes();
    clearLanes();
    tAct = '1;
    for (int i = 0; i < LANES; i++) tAddr[i] = 8*i;
    runGroup(1'b0, 1'b0, 2, "R1 stride8 narrow");
    runGroup(1'b0, 1'b1, 1, "R2 stride8 wide");
    for (int i = 0; i < LANES; i++) tAddr[i] = 4*i;
    runGroup(1'b0, 1'b1, 1, "R2 half words wide");
    check(laneData(5) == 105, "R2 odd half data", laneData(5), 105);
    check(laneData(4) == 104, "R2 even half data", laneData(4), 104);
  endtask

  task automatic t_serial();
    clearLanes();
    tAct = '1;
    for (int i = 0; i < LANES; i++) begin
      tAddr[i] = 128*i;
      tData[i] = 200 + i;
    end
    runGroup(1'b1, 1'b0, 32, "R3 worst write");
    runGroup(1'b0, 1'b0, 32, "R3 worst read");
    for (int i = 0; i < LANES; i++)
      check(laneData(i) == 200 + i, "R3 worst read data", laneData(i), 200 + i);
    clearLanes();
    tAct = 32'h7;
    tAddr[0] = 0; tAddr[1] = 256; tAddr[2] = 512;
    runGroup(1'b0, 1'b1, 3, "R3 three wide words");
  endtask

  task automatic t_broadcast();
    clearLanes();
    tAct = '1;
    for (int i = 0; i < LANES; i++) tAddr[i] = 640;
    runGroup(1'b0, 1'b0, 1, "R4 broadcast");
    for (int i = 0; i < LANES; i++)
      check(laneData(i) == 205, "R4 broadcast data", laneData(i), 205);
  endtask

  task automatic t_sameWrite();
    clearLanes();
    tAct[3] = 1'b1; tAct[7] = 1'b1; tAct[20] = 1'b1;
    tAddr[3] = 'h40; tAddr[7] = 'h40; tAddr[20] = 'h40;
    tData[3] = 333; tData[7] = 777; tData[20] = 2020;
    runGroup(1'b1, 1'b0, 1, "R5 same word write");
    clearLanes();
    tAct[0] = 1'b1;
    tAddr[0] = 'h40;
    runGroup(1'b0, 1'b0, 1, "R5 readback");
    check(laneData(0) == 333, "R5 lowest lane wins", laneData(0), 333);
  endtask

  task automatic t_order();
    clearLanes();
    tAct = 32'hF;
    tAddr[0] = 0; tAddr[1] = 128; tAddr[2] = 128; tAddr[3] = 0;
    runGroup(1'b0, 1'b0, 2, "R6 grouped retire");
    check(laneData(3) == 200, "R6 lane3 data", laneData(3), 200);
    check(laneData(2) == 201, "R6 lane2 data", laneData(2), 201);
  endtask

  task automatic t_inactive();
    clearLanes();
    tAct[5] = 1'b1;
    tAddr[5] = 24; tData[5] = 'hABC;
    tAddr[6] = 28; tData[6] = 'hDEF;
    runGroup(1'b1, 1'b0, 1, "R9 single lane write");
    clearLanes();
    tAct = '1;
    for (int i = 0; i < LANES; i++) tAddr[i] = 4*i;
    runGroup(1'b0, 1'b0, 1, "R9 readback");
    check(laneData(6) == 'hABC, "R9 active write landed", laneData(6), 'hABC);
    check(laneData(7) == 107, "R9 inactive lane no write", laneData(7), 107);
    tAct = 32'h1;
    runGroup(1'b0, 1'b0, 1, "R9 one lane read");
    check(laneData(9) == 0, "R9 inactive lane reads 0", laneData(9), 0);
    check(laneData(0) == 200, "R9 active lane data", laneData(0), 200);
    repeat (3) @(negedge clk);
    check(laneData(0) == 200, "R10 data held", laneData(0), 200);
    check(passCount == 6'd1, "R11 count held", int'(passCount), 1);
    tAct = '0;
    runGroup(1'b0, 1'b0, 0, "R9 empty group");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_linear();
    t_modes();
    t_serial();
    t_broadcast();
    t_sameWrite();
    t_order();
    t_inactive();
    @(negedge clk);
    check(rspDone == 1'b0, "R7 done one cycle", int'(rspDone), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule